// File: doc/BRIEF.md
# Keypad Event Reader over I2C

This block is an I2C-bus target that hands key events from an adjacent event queue to a bus controller. An event is two bytes: a key code and a duration byte whose top bit flags a timer overflow and whose low seven bits hold the press time. The controller addresses the block for reading, receives the key code, acknowledges it, receives the duration, acknowledges that too, and ends with STOP.

SCL and SDA are brought into the system clock domain through a short flip-flop chain and edge-detected there. SDA is open-drain: the block only ever pulls it low through `sda_pull`. The queue is consumed only when both bytes of an event were acknowledged. A not-acknowledge, a STOP or a repeated START before that point leaves the event in place, so the next read returns it again. The two low address bits come from strap inputs, so up to four such blocks can share one bus.

Top module: `kev_i2c_reader`

## Requirements
- R1: A START (SDA falling while SCL is high) in any state releases SDA and restarts address reception. A STOP (SDA rising while SCL is high) releases SDA and returns the block to idle. An aborted read does not consume the event.
- R2: An address byte equal to {5'b01000, strap[1:0]}, sent MSB first and followed by a R/W bit of 1, is acknowledged: SDA is held low through the high phase of the ninth clock.
- R3: An address byte with other upper bits, other strap bits, or R/W = 0 is not acknowledged. SDA stays released until the next START.
- R4: After the address acknowledge, the key code is sent MSB first, one bit per SCL clock. SDA only changes while SCL is low.
- R5: After a controller ACK (SDA low on the ninth clock), the duration byte is sent MSB first. Bit 7 is the overflow flag and bits 6..0 are the time.
- R6: A controller ACK after the duration byte produces exactly one `evq_pop` pulse, one system clock wide, while SCL is high in that ninth clock.
- R7: A controller NACK (SDA high on the ninth clock) after either byte produces no pop, and the next read returns the same event.
- R8: When the queue is empty at the address acknowledge, the read returns key code 8'hFF and duration 8'h00, and no pop is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed level of the SCL line |
| sda_in | input | 1 | Sensed level of the SDA line |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 2 | Two low address bits |
| evq_empty | input | 1 | Event queue holds no event |
| evq_key | input | 8 | Key code of the oldest event |
| evq_dur | input | 8 | Duration byte of the oldest event |
| evq_pop | output | 1 | One-cycle strobe that removes the oldest event |

## Verification
Every bus edge passes through two synchroniser stages and one edge register. The block's SDA response therefore lands three to four system clocks after the SCL edge that causes it. The controller model keeps each SCL phase 40 clocks long and samples SDA 20 clocks into the high phase, well after any response has settled and well before the next edge. The pop strobe is due about four clocks after the final ninth-clock rise. The bench counts strobe cycles over a whole transaction, so one late or doubled pulse still shows up. A monitor flags any change of `sda_pull` while SCL is high.

// File: rtl/kev_pkg.sv
package kev_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_TACK
  } kev_state_e;
endpackage

// File: rtl/kev_bus_sync.sv
module kev_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/kev_ctrl.sv
module kev_ctrl
  import kev_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int STRAP_W = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 5'b01000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic               evq_empty,
  input  logic [DATA_W-1:0]  evq_key,
  input  logic [DATA_W-1:0]  evq_dur,
  output logic               sda_pull,
  output logic               evq_pop
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(DATA_W);

  kev_state_e        state, n_state;
  logic [CNT_W-1:0]  bitcnt, n_bitcnt;
  logic [DATA_W-1:0] shreg, n_shreg;
  logic [DATA_W-1:0] dur_l, n_dur_l;
  logic              have_l, n_have_l;
  logic              idx, n_idx;
  logic              acked, n_acked;
  logic              pull, n_pull;
  logic              pop, n_pop;
  logic              addr_hit;

  assign addr_hit = (shreg[DATA_W-1:1] == {ADDR_HI, strap}) && shreg[0];

  always_comb begin
    n_state  = state;
    n_bitcnt = bitcnt;
    n_shreg  = shreg;
    n_dur_l  = dur_l;
    n_have_l = have_l;
    n_idx    = idx;
    n_acked  = acked;
    n_pull   = pull;
    n_pop    = 1'b0;
    if (start_det) begin
      n_state  = ST_ADDR;
      n_bitcnt = '0;
      n_pull   = 1'b0;
      n_acked  = 1'b0;
      n_idx    = 1'b0;
    end else if (stop_det) begin
      n_state = ST_IDLE;
      n_pull  = 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            n_shreg  = {shreg[DATA_W-2:0], sda_s};
            n_bitcnt = bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == ADDR_END) begin
            if (addr_hit) begin
              n_pull  = 1'b1;
              n_state = ST_AACK;
            end else begin
              n_state = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            n_shreg  = evq_empty ? '1 : evq_key;
            n_dur_l  = evq_empty ? '0 : evq_dur;
            n_have_l = ~evq_empty;
            n_pull   = evq_empty ? 1'b0 : ~evq_key[DATA_W-1];
            n_bitcnt = '0;
            n_idx    = 1'b0;
            n_state  = ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              n_pull  = 1'b0;
              n_acked = 1'b0;
              n_state = ST_TACK;
            end else begin
              n_shreg  = {shreg[DATA_W-2:0], 1'b0};
              n_pull   = ~shreg[DATA_W-2];
              n_bitcnt = bitcnt + 1'b1;
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            if (sda_s) begin
              n_state = ST_IDLE;
            end else if (idx) begin
              n_pop   = have_l;
              n_state = ST_IDLE;
            end else begin
              n_acked = 1'b1;
            end
          end else if (scl_fall && acked) begin
            n_shreg  = dur_l;
            n_pull   = ~dur_l[DATA_W-1];
            n_bitcnt = '0;
            n_idx    = 1'b1;
            n_acked  = 1'b0;
            n_state  = ST_TX;
          end
        end
        default: n_state = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      dur_l  <= '0;
      have_l <= 1'b0;
      idx    <= 1'b0;
      acked  <= 1'b0;
      pull   <= 1'b0;
      pop    <= 1'b0;
    end else begin
      state  <= n_state;
      bitcnt <= n_bitcnt;
      shreg  <= n_shreg;
      dur_l  <= n_dur_l;
      have_l <= n_have_l;
      idx    <= n_idx;
      acked  <= n_acked;
      pull   <= n_pull;
      pop    <= n_pop;
    end
  end

  assign sda_pull = pull;
  assign evq_pop  = pop;
endmodule

// File: rtl/kev_i2c_reader.sv
module kev_i2c_reader #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int STRAP_W     = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 5'b01000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  input  logic [STRAP_W-1:0] strap,
  input  logic               evq_empty,
  input  logic [DATA_W-1:0]  evq_key,
  input  logic [DATA_W-1:0]  evq_dur,
  output logic               evq_pop
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  kev_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  kev_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(strap), .evq_empty(evq_empty), .evq_key(evq_key),
    .evq_dur(evq_dur), .sda_pull(sda_pull), .evq_pop(evq_pop)
  );
endmodule

// File: rtl/kev_i2c_reader_chk.sv
module kev_i2c_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_pull,
  input logic evq_pop
);
  assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull);

  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  assert_sda_moves_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  assert_pop_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evq_pop |=> !evq_pop);

  assert_pop_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evq_pop |-> scl_s);
endmodule

bind kev_i2c_reader kev_i2c_reader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_pull(sda_pull), .evq_pop(evq_pop)
);

// File: tb/kev_i2c_reader_tb_top.sv
module kev_i2c_reader_tb_top;
  localparam int HALF = 20;
  localparam int NEV  = 4;

  logic       clk, rst_n, scl, mst_sda;
  logic [1:0] strap;
  logic       sda_pull, evq_pop, evq_empty;
  logic [7:0] evq_key, evq_dur;
  logic       sda_bus;
  logic [7:0] mem_key [NEV];
  logic [7:0] mem_dur [NEV];
  int         rd_ptr, pop_cycles, viol_cnt, pull_cycles;
  int         n_chk, n_bad;
  logic       prev_pull;
  bit         done;

  assign sda_bus   = mst_sda & ~sda_pull;
  assign evq_empty = (rd_ptr >= NEV);
  assign evq_key   = evq_empty ? 8'h00 : mem_key[rd_ptr];
  assign evq_dur   = evq_empty ? 8'h00 : mem_dur[rd_ptr];

  kev_i2c_reader dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .sda_pull(sda_pull), .strap(strap), .evq_empty(evq_empty),
    .evq_key(evq_key), .evq_dur(evq_dur), .evq_pop(evq_pop)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= 0; pop_cycles <= 0; viol_cnt <= 0; pull_cycles <= 0; prev_pull <= 1'b0;
    end else begin
      prev_pull <= sda_pull;
      if (evq_pop) begin
        rd_ptr <= rd_ptr + 1;
        pop_cycles <= pop_cycles + 1;
      end
      if (sda_pull) pull_cycles <= pull_cycles + 1;
      if (sda_pull != prev_pull && scl) viol_cnt <= viol_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    mst_sda = 1'b1; wclk(HALF);
    scl = 1'b1;     wclk(HALF);
    mst_sda = 1'b0; wclk(HALF);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    wclk(HALF); mst_sda = 1'b0; wclk(HALF);
    scl = 1'b1; wclk(HALF);
    mst_sda = 1'b1; wclk(HALF);
  endtask

  task automatic put_bit(input logic b);
    wclk(HALF); mst_sda = b; wclk(HALF);
    scl = 1'b1; wclk(2 * HALF);
    scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    mst_sda = 1'b1; wclk(2 * HALF);
    scl = 1'b1; wclk(HALF);
    b = sda_bus; wclk(HALF);
    scl = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
  endtask

  // full transaction; ack1/ack2 = 1 means controller acknowledges
  task automatic xfer(input logic [7:0] abyte, input bit ack1, input bit ack2,
                      output bit aack, output logic [7:0] k, output logic [7:0] d);
    logic b;
    k = 8'hxx; d = 8'hxx;
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(abyte[i]);
    get_bit(b);
    aack = !b;
    if (aack) begin
      get_byte(k);
      put_bit(!ack1);
      if (ack1) begin
        get_byte(d);
        put_bit(!ack2);
      end
    end
    bus_stop();
  endtask

  task automatic t_reset();
    check(sda_pull == 1'b0, "R1 reset sda released", sda_pull, 0);
    check(evq_pop == 1'b0, "R6 reset no pop", evq_pop, 0);
  endtask

  task automatic t_normal();
    bit a; logic [7:0] k, d; int p0 = pop_cycles;
    xfer({5'b01000, strap, 1'b1}, 1, 1, a, k, d);
    check(a, "R2 address ack", a, 1);
    check(k == 8'hA5, "R4 key byte", k, 8'hA5);
    check(d == 8'h83, "R5 duration byte", d, 8'h83);
    check(pop_cycles - p0 == 1, "R6 single pop", pop_cycles - p0, 1);
  endtask

  task automatic t_nack_key();
    bit a; logic [7:0] k, d; int p0 = pop_cycles;
    xfer({5'b01000, strap, 1'b1}, 0, 0, a, k, d);
    check(k == 8'h6E, "R7 key before nack", k, 8'h6E);
    check(pop_cycles == p0, "R7 no pop on key nack", pop_cycles - p0, 0);
    xfer({5'b01000, strap, 1'b1}, 1, 1, a, k, d);
    check(k == 8'h6E && d == 8'h05, "R7 same event after key nack", {k, d}, 16'h6E05);
    check(pop_cycles - p0 == 1, "R6 pop after reread", pop_cycles - p0, 1);
  endtask

  task automatic t_nack_dur();
    bit a; logic [7:0] k, d; int p0 = pop_cycles;
    xfer({5'b01000, strap, 1'b1}, 1, 0, a, k, d);
    check(d == 8'h8A, "R5 overflow flag set", d, 8'h8A);
    check(pop_cycles == p0, "R7 no pop on dur nack", pop_cycles - p0, 0);
    xfer({5'b01000, strap, 1'b1}, 1, 1, a, k, d);
    check(k == 8'hC3 && d == 8'h8A, "R7 same event after dur nack", {k, d}, 16'hC38A);
  endtask

  task automatic t_bad_addr();
    bit a; logic [7:0] k, d; int p0 = pop_cycles; int q0 = pull_cycles;
    xfer({5'b01000, ~strap, 1'b1}, 1, 1, a, k, d);
    check(!a, "R3 wrong strap not acked", a, 0);
    xfer({5'b11000, strap, 1'b1}, 1, 1, a, k, d);
    check(!a, "R3 wrong upper bits not acked", a, 0);
    xfer({5'b01000, strap, 1'b0}, 1, 1, a, k, d);
    check(!a, "R3 write direction not acked", a, 0);
    check(pull_cycles == q0, "R3 sda never pulled", pull_cycles - q0, 0);
    check(pop_cycles == p0, "R3 no pop", pop_cycles - p0, 0);
  endtask

  task automatic t_restart();
    bit a; logic [7:0] k, d; logic b; int p0 = pop_cycles;
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(((8'h40 | (strap << 1) | 8'h01) >> i) & 1);
    get_bit(b);
    for (int i = 0; i < 3; i++) get_bit(b);
    bus_start();
    wclk(4);
    check(sda_pull == 1'b0, "R1 repeated start releases", sda_pull, 0);
    scl = 1'b1; wclk(HALF); mst_sda = 1'b0; wclk(HALF); bus_stop();
    check(sda_pull == 1'b0 && pop_cycles == p0, "R1 stop idles, no pop",
          pop_cycles - p0, 0);
    xfer({5'b01000, strap, 1'b1}, 1, 1, a, k, d);
    check(k == 8'h5B && d == 8'h41, "R1 aborted event reread", {k, d}, 16'h5B41);
  endtask

  task automatic t_empty();
    bit a; logic [7:0] k, d; int p0 = pop_cycles;
    xfer({5'b01000, strap, 1'b1}, 1, 1, a, k, d);
    check(a, "R8 ack while empty", a, 1);
    check(k == 8'hFF, "R8 empty key", k, 8'hFF);
    check(d == 8'h00, "R8 empty duration", d, 0);
    check(pop_cycles == p0, "R8 no pop when empty", pop_cycles - p0, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    mem_key[0] = 8'hA5; mem_dur[0] = 8'h83;
    mem_key[1] = 8'h6E; mem_dur[1] = 8'h05;
    mem_key[2] = 8'hC3; mem_dur[2] = 8'h8A;
    mem_key[3] = 8'h5B; mem_dur[3] = 8'h41;
    scl = 1'b1; mst_sda = 1'b1; strap = 2'b10; rst_n = 1'b0;
    wclk(5);
    t_reset();
    rst_n = 1'b1;
    wclk(10);
    t_normal();
    t_nack_key();
    t_bad_addr();
    t_nack_dur();
    t_restart();
    t_empty();
    check(viol_cnt == 0, "R4 sda stable while scl high", viol_cnt, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule